// File: doc/BRIEF.md
# Serial Flash Page-Size Configuration Sequencer

This block runs once after every reset, before anything else uses an attached serial flash. It drives a byte-level SPI master: it owns the chip select and issues one byte at a time through a start/done handshake. It first reads the flash status register. The memory may already be organised in power-of-two pages. If so, the block raises its ready output and leaves the bus idle from then on.

If the memory still uses the non-binary page size, the block sends the fixed four-byte conversion command inside one chip-select frame. It then polls the status register until the busy flag clears, or until a bounded number of polls has been made. Last, it checks the page-size bit once more. The result is reported on an error output, which is valid whenever ready is high.

The bit shifter, the SCK polarity and the sampling edge all belong to the SPI master behind the byte handshake. The shifter may run in mode 0 or mode 3 without any change to this block.

Top module: `pgcfg_seq`

## Requirements
- R1: While reset is asserted, chip select is high (deselected), start is low, ready is low and error is low.
- R2: The first frame after reset is a status read. It is opcode 0xD7 followed by one dummy byte 0x00, inside one chip-select assertion. The byte received during the dummy byte is taken as status byte 1.
- R3: If bit 0 of that status byte is 1, meaning binary pages, ready rises with error low and no further frame is sent.
- R4: If bit 0 is 0, the next frame is exactly 0x3D, 0x2A, 0x80, 0xA6 in that order, inside one chip-select assertion.
- R5: Chip select stays high for at least GAP_CYCLES clock cycles before every frame, including the first.
- R6: After the conversion frame, status reads (0xD7, 0x00) are repeated while the device reports busy. With the default polarity, bit 7 of the status byte equal to 1 means the device is not busy.
- R7: After MAX_POLLS status reads that all report busy, the block stops polling and finishes with error high.
- R8: When a poll reports not busy, the block finishes. Error is low if bit 0 now reads 1, and high if bit 0 reads 0.
- R9: Once ready is high, it stays high until the next reset. Error does not change after that point and is never high while ready is low. No start pulse is issued and chip select stays high while ready is high.
- R10: Start is a single-cycle pulse. It is issued only while chip select is low and no byte is pending. The transmit byte stays stable and chip select stays low until done returns.
- R11: A reset asserted in the middle of the sequence aborts it. After release, the sequence starts again from the status read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_start | output | 1 | One-cycle request to exchange one byte |
| spi_tx | output | 8 | Byte to send, held until done |
| spi_done | input | 1 | One-cycle pulse: byte exchange finished |
| spi_rx | input | 8 | Byte received, valid with spi_done |
| cfg_ready | output | 1 | Sequence complete, sticky until reset |
| cfg_error | output | 1 | Device could not be confirmed in binary page mode |

## Verification
The bench builds the block with GAP_CYCLES = 2 and MAX_POLLS = 4. A poll limit of four lets a short device model reach both edges of the polling window in a few frames: the last allowed poll succeeding, and every allowed poll reporting busy. The two-cycle gap is long enough to tell a true idle gap from a one-cycle glitch on chip select. The default polarity of the busy flag is used, so the model reports busy by clearing bit 7.

// File: rtl/pgcfg_pkg.sv
package pgcfg_pkg;

   localparam logic [7:0] OP_STATUS_RD = 8'hD7;
   localparam logic [7:0] DUMMY_BYTE   = 8'h00;

   // Fixed page-size conversion frame, sent in this order.
   localparam int         CONV_LEN = 4;
   localparam logic [7:0] CONV_SEQ [CONV_LEN] = '{8'h3D, 8'h2A, 8'h80, 8'hA6};

   // Byte index width covers the longest frame.
   localparam int IDX_W = $clog2(CONV_LEN);

   typedef enum logic [2:0] {
      ST_DESEL,
      ST_GAP,
      ST_SEL,
      ST_START,
      ST_WAIT,
      ST_FINISH
   } seq_state_e;

   typedef enum logic [1:0] {
      PH_BOOT,
      PH_CHECK,
      PH_CONVERT,
      PH_POLL
   } seq_phase_e;

endpackage

// File: rtl/pgcfg_frame_rom.sv
module pgcfg_frame_rom
   import pgcfg_pkg::*;
(
   input  logic             is_conv,
   input  logic [IDX_W-1:0] idx,
   output logic [7:0]       data_o,
   output logic [IDX_W-1:0] last_o
);

   always_comb begin
      if (is_conv) begin
         data_o = CONV_SEQ[idx];
         last_o = IDX_W'(CONV_LEN - 1);
      end else begin
         data_o = (idx == '0) ? OP_STATUS_RD : DUMMY_BYTE;
         last_o = IDX_W'(1);
      end
   end

endmodule

// File: rtl/pgcfg_gap_timer.sv
module pgcfg_gap_timer #(
   parameter int CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expired
);

   localparam int CW = $clog2(CYCLES + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= CW'(CYCLES);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/pgcfg_poll_ctr.sv
module pgcfg_poll_ctr #(
   parameter int LIMIT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic at_last
);

   localparam int CW = $clog2(LIMIT + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else if (inc) cnt_q <= cnt_q + 1'b1;
   end

   assign at_last = (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/pgcfg_seq.sv
module pgcfg_seq
   import pgcfg_pkg::*;
#(
   parameter int GAP_CYCLES  = 2,
   parameter int MAX_POLLS   = 64,
   parameter int PG_BIT      = 0,
   parameter int BUSY_BIT    = 7,
   parameter bit BUSY_SET_IS_READY = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   output logic       spi_cs_n,
   output logic       spi_start,
   output logic [7:0] spi_tx,
   input  logic       spi_done,
   input  logic [7:0] spi_rx,
   output logic       cfg_ready,
   output logic       cfg_error
);

   localparam logic [7:0] PG_MASK   = 8'(1) << PG_BIT;
   localparam logic [7:0] BUSY_MASK = 8'(1) << BUSY_BIT;

   // Elaboration-time parameter checks
   if (GAP_CYCLES < 1) begin : g_bad_gap
      $error("GAP_CYCLES must be at least 1");
   end
   if (MAX_POLLS < 1) begin : g_bad_polls
      $error("MAX_POLLS must be at least 1");
   end
   if (PG_BIT < 0 || PG_BIT > 7 || BUSY_BIT < 0 || BUSY_BIT > 7) begin : g_bad_bits
      $error("status bit positions must lie in 0..7");
   end

   seq_state_e       state_q;
   seq_phase_e       phase_q;
   logic             conv_q;
   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] last_idx;
   logic [7:0]       st_q;
   logic             cs_n_q, ready_q, err_q;
   logic             gap_over, dev_busy, page_ok, poll_last;
   logic             poll_clr, poll_inc, decide;

   pgcfg_frame_rom u_rom (
      .is_conv (conv_q),
      .idx     (idx_q),
      .data_o  (spi_tx),
      .last_o  (last_idx)
   );

   pgcfg_gap_timer #(.CYCLES(GAP_CYCLES)) u_gap (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (state_q == ST_DESEL),
      .expired (gap_over)
   );

   pgcfg_poll_ctr #(.LIMIT(MAX_POLLS)) u_poll (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (poll_clr),
      .inc     (poll_inc),
      .at_last (poll_last)
   );

   // Busy flag polarity variant
   if (BUSY_SET_IS_READY) begin : g_busy_when_clear
      assign dev_busy = (st_q & BUSY_MASK) == 8'h00;
   end else begin : g_busy_when_set
      assign dev_busy = (st_q & BUSY_MASK) != 8'h00;
   end

   assign page_ok  = (st_q & PG_MASK) != 8'h00;
   assign decide   = (state_q == ST_GAP) && gap_over;
   assign poll_clr = decide && (phase_q == PH_CONVERT);
   assign poll_inc = decide && (phase_q == PH_POLL) && dev_busy && !poll_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_DESEL;
         phase_q <= PH_BOOT;
         conv_q  <= 1'b0;
         idx_q   <= '0;
         st_q    <= '0;
         cs_n_q  <= 1'b1;
         ready_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_DESEL: begin
               cs_n_q  <= 1'b1;
               state_q <= ST_GAP;
            end
            ST_GAP: begin
               if (gap_over) begin
                  unique case (phase_q)
                     PH_BOOT: begin
                        phase_q <= PH_CHECK;
                        conv_q  <= 1'b0;
                        state_q <= ST_SEL;
                     end
                     PH_CHECK: begin
                        if (page_ok) begin
                           ready_q <= 1'b1;
                           state_q <= ST_FINISH;
                        end else begin
                           phase_q <= PH_CONVERT;
                           conv_q  <= 1'b1;
                           state_q <= ST_SEL;
                        end
                     end
                     PH_CONVERT: begin
                        phase_q <= PH_POLL;
                        conv_q  <= 1'b0;
                        state_q <= ST_SEL;
                     end
                     default: begin
                        if (dev_busy && !poll_last) begin
                           state_q <= ST_SEL;
                        end else begin
                           ready_q <= 1'b1;
                           err_q   <= dev_busy || !page_ok;
                           state_q <= ST_FINISH;
                        end
                     end
                  endcase
               end
            end
            ST_SEL: begin
               cs_n_q  <= 1'b0;
               idx_q   <= '0;
               state_q <= ST_START;
            end
            ST_START: state_q <= ST_WAIT;
            ST_WAIT: begin
               if (spi_done) begin
                  if (!conv_q && idx_q == IDX_W'(1)) st_q <= spi_rx;
                  if (idx_q == last_idx) begin
                     state_q <= ST_DESEL;
                  end else begin
                     idx_q   <= idx_q + 1'b1;
                     state_q <= ST_START;
                  end
               end
            end
            default: state_q <= ST_FINISH;
         endcase
      end
   end

   assign spi_cs_n  = cs_n_q;
   assign spi_start = (state_q == ST_START);
   assign cfg_ready = ready_q;
   assign cfg_error = err_q;

endmodule

// File: rtl/pgcfg_seq_chk.sv
module pgcfg_seq_chk #(
   parameter int GAP_CYCLES = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       spi_cs_n,
   input logic       spi_start,
   input logic [7:0] spi_tx,
   input logic       spi_done,
   input logic       cfg_ready,
   input logic       cfg_error
);

   localparam int HW = $clog2(GAP_CYCLES + 1) + 1;

   logic          pend_q;
   logic [HW-1:0] hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pend_q <= 1'b0;
      else if (spi_done)  pend_q <= 1'b0;
      else if (spi_start) pend_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          hi_q <= '0;
      else if (!spi_cs_n)                  hi_q <= '0;
      else if (hi_q < HW'(GAP_CYCLES))     hi_q <= hi_q + 1'b1;
   end

   assert_start_cs_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      spi_start |-> !spi_cs_n);
   assert_start_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      spi_start |=> !spi_start);
   assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      spi_start |-> !pend_q);
   assert_cs_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> !spi_cs_n);
   assert_tx_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> $stable(spi_tx));
   assert_gap_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_cs_n) |-> hi_q >= HW'(GAP_CYCLES));
   assert_ready_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_ready |=> cfg_ready);
   assert_err_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_ready |=> $stable(cfg_error));
   assert_err_needs_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_error |-> cfg_ready);
   assert_bus_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_ready |-> (spi_cs_n && !spi_start));

endmodule

bind pgcfg_seq pgcfg_seq_chk #(.GAP_CYCLES(GAP_CYCLES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .spi_cs_n  (spi_cs_n),
   .spi_start (spi_start),
   .spi_tx    (spi_tx),
   .spi_done  (spi_done),
   .cfg_ready (cfg_ready),
   .cfg_error (cfg_error)
);

// File: tb/tb_pgcfg_seq.sv
module tb_pgcfg_seq;

   localparam int GAP   = 2;
   localparam int POLLS = 4;
   localparam int LAT   = 3;
   localparam int LOGN  = 32;
   localparam int NVEC  = 6;

   // Vector table: initial bit 0, busy polls, final bit 0, frames, error
   localparam int V_INIT [NVEC] = '{1, 0, 0, 0, 0, 0};
   localparam int V_BUSY [NVEC] = '{0, 0, 2, 3, 4, 0};
   localparam int V_FIN  [NVEC] = '{1, 1, 1, 1, 1, 0};
   localparam int V_FRM  [NVEC] = '{1, 3, 5, 6, 6, 3};
   localparam int V_ERR  [NVEC] = '{0, 0, 0, 0, 1, 1};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       spi_cs_n, spi_start, spi_done, cfg_ready, cfg_error;
   logic [7:0] spi_tx, spi_rx;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   // Device model state
   int         init_b0, busy_n, fin_b0;
   int         pend_cnt, pos, frames, n_log, polls_seen, hi_run, gap_bad, proto_bad;
   bit         conv_seen, cs_prev;
   logic [7:0] first_b, resp;
   logic [7:0] log_b [LOGN];

   always #5 clk = ~clk;

   pgcfg_seq #(.GAP_CYCLES(GAP), .MAX_POLLS(POLLS)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .spi_cs_n  (spi_cs_n),
      .spi_start (spi_start),
      .spi_tx    (spi_tx),
      .spi_done  (spi_done),
      .spi_rx    (spi_rx),
      .cfg_ready (cfg_ready),
      .cfg_error (cfg_error)
   );

   // Byte-level SPI master plus flash model, reacting between clock edges
   always @(negedge clk) begin
      if (!rst_n) begin
         spi_done = 1'b0; spi_rx = 8'h00; pend_cnt = 0; pos = 0; frames = 0;
         n_log = 0; polls_seen = 0; conv_seen = 1'b0; cs_prev = 1'b1;
         hi_run = GAP; gap_bad = 0; proto_bad = 0; first_b = 8'h00;
      end else begin
         spi_done = 1'b0;
         if (spi_cs_n) pos = 0;
         if (!spi_cs_n && cs_prev) begin
            frames++;
            if (hi_run < GAP) gap_bad++;
         end
         hi_run  = spi_cs_n ? hi_run + 1 : 0;
         cs_prev = spi_cs_n;
         if (pend_cnt > 0) begin
            pend_cnt--;
            if (pend_cnt == 0) begin
               spi_done = 1'b1;
               spi_rx   = resp;
               pos++;
            end
         end else if (spi_start) begin
            if (spi_cs_n) proto_bad++;
            if (n_log < LOGN) log_b[n_log] = spi_tx;
            n_log++;
            if (pos == 0) first_b = spi_tx;
            resp = 8'hFF;
            if (pos == 1 && first_b == 8'hD7) begin
               if (!conv_seen)               resp = {1'b1, 6'b0, init_b0[0]};
               else if (polls_seen < busy_n) resp = 8'h00;
               else                          resp = {1'b1, 6'b0, fin_b0[0]};
               if (conv_seen) polls_seen++;
            end
            if (pos == 3 && spi_tx == 8'hA6) conv_seen = 1'b1;
            pend_cnt = LAT;
         end else if (spi_start) begin
            proto_bad++;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_byte(input int v, input int i);
      logic [7:0] conv [4] = '{8'h3D, 8'h2A, 8'h80, 8'hA6};
      if (i < 2)            return (i == 0) ? 8'hD7 : 8'h00;
      if (V_INIT[v] == 1)   return 8'hEE;
      if (i < 6)            return conv[i-2];
      return ((i - 6) % 2 == 0) ? 8'hD7 : 8'h00;
   endfunction

   function automatic string tag_of(input int v);
      case (v)
         0: return "R3";
         1: return "R4";
         2: return "R6";
         3: return "R6";
         4: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic start_seq(input int v);
      init_b0 = V_INIT[v];
      busy_n  = V_BUSY[v];
      fin_b0  = V_FIN[v];
      rst_n   = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state {cs_n, start, ready, error}
      chk({spi_cs_n, spi_start, cfg_ready, cfg_error} == 4'b1000, "R1",
          {spi_cs_n, spi_start, cfg_ready, cfg_error}, 4'b1000);
      rst_n = 1'b1;
   endtask

   task automatic run_vector(input int v);
      int bad;
      int logged;
      start_seq(v);
      for (int c = 0; c < 3000 && !cfg_ready; c++) @(negedge clk);
      chk(cfg_ready == 1'b1, "R9", cfg_ready, 1);
      chk(cfg_error == V_ERR[v][0], tag_of(v), cfg_error, V_ERR[v]);
      chk(frames == V_FRM[v], tag_of(v), frames, V_FRM[v]);
      chk(n_log == 2 * V_FRM[v] + (V_INIT[v] == 0 ? 2 : 0), "R2", n_log,
          2 * V_FRM[v] + (V_INIT[v] == 0 ? 2 : 0));
      bad = 0;
      for (int i = 0; i < n_log && i < LOGN; i++)
         if (log_b[i] !== exp_byte(v, i)) bad++;
      // R2 status read bytes, R4 conversion bytes, R6 poll bytes
      chk(bad == 0, (V_INIT[v] == 1) ? "R2" : "R4", bad, 0);
      logged = n_log;
      repeat (40) @(negedge clk);
      chk(cfg_ready && spi_cs_n && n_log == logged && cfg_error == V_ERR[v][0], "R9",
          n_log, logged);
      chk(gap_bad == 0, "R5", gap_bad, 0);
      chk(proto_bad == 0, "R10", proto_bad, 0);
   endtask

   initial begin
      for (int v = 0; v < NVEC; v++) run_vector(v);

      // R11: reset in the middle of the conversion, then a full rerun
      start_seq(2);
      for (int c = 0; c < 3000 && !(frames >= 2 && n_log >= 4); c++) @(negedge clk);
      chk(!cfg_ready && !spi_cs_n, "R11", {cfg_ready, spi_cs_n}, 2'b00);
      run_vector(2);
      chk(log_b[0] == 8'hD7 && frames == 5 && !cfg_error, "R11", log_b[0], 8'hD7);

      // R8: a poll that ends with bit 0 still clear reports error
      run_vector(5);
      chk(cfg_error == 1'b1 && cfg_ready == 1'b1, "R8", cfg_error, 1);

      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

endmodule